// File: doc/BRIEF.md
# Configuration Request Router with PCI-Side Gate

This block makes the routing decision for every configuration request that reaches a PCI bridge. Requests come from one of two sides. A request from the on-chip local bus is sent to one of three places: the bridge's own configuration register file, a type 0 configuration cycle on PCI, or a type 1 configuration cycle on PCI. The choice depends on the bus and device fields of the request. A local request may also force a cycle type. If the forced type is illegal for the given fields, the block flags it and issues nothing.

A request from the PCI side always targets the bridge itself. The block screens it in three steps. First, while the host-configuration enable flag is clear, the request is answered with retry. Second, a window of register offsets that holds local-only control and the address/data indirection pair cannot be reached from PCI. Third, identity registers and the bridge option register are read-only from PCI but writable from the local side. The enable flag is held inside the block. A local-side write to the bridge option register offset updates the flag from bit 0 of the write data.

Each request gives one registered response, one cycle later. The response carries a route code, a retry flag, an error pulse, and a flag that tells the data path to return all ones on a read. The register contents and the PCI signalling are handled outside this block.

Top module: `cfg_route_gate`

## Requirements
- R1: After reset, rsp_valid, rsp_retry, rsp_error and rsp_ones are 0, rsp_route is 0, and the host-configuration enable flag is 0.
- R2: A local request (req_side=0) of kind AUTO (req_kind=0) with bus 0 and device 0 responds with route INTERNAL (rsp_route=1) and no error.
- R3: A local AUTO request with bus 0 and a nonzero device responds with route TYPE0 (rsp_route=2).
- R4: A local AUTO request with a nonzero bus responds with route TYPE1 (rsp_route=3), whatever the device number.
- R5: A local request of kind forced-type-0 (req_kind=2) with device 0 is flagged as an error. So is forced-type-1 (req_kind=3) with bus 0, and so is the reserved kind (req_kind=1). In each of these cases rsp_error=1 and rsp_route=0 (NONE). Legal forced requests give route 2 or 3 respectively.
- R6: A PCI-side request (req_side=1) made while the enable flag is 0 responds with rsp_retry=1, rsp_route=0 and rsp_error=0.
- R7: With the flag set, a PCI-side request to register offsets 0xF0 through 0xFF responds with rsp_error=1 and route 0.
- R8: With the flag set, a PCI-side write to offsets 0x00-0x03, 0x08-0x0B, 0x2C-0x2F or 0x60-0x63 responds with rsp_error=1 and route 0. A PCI-side read of these offsets, and a local write to them, gives route INTERNAL.
- R9: A local write (req_write=1) that routes INTERNAL to offset 0x60 loads the enable flag from req_wbit0. The new value applies to the next request. Reads do not change the flag, and neither do PCI-side writes.
- R10: Each request accepted in a cycle produces exactly one response with rsp_valid=1 in the next cycle. With no request, rsp_valid is 0. rsp_error lasts one cycle per flagged request.
- R11: rsp_ones is 1 exactly when a flagged request (R5, R7, R8) is a read.
- R12: For PCI-side requests, the bus, device and kind fields have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_side | input | 1 | 0 = local bus side, 1 = PCI side |
| req_kind | input | 2 | 0 auto, 1 reserved, 2 force type 0, 3 force type 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wbit0 | input | 1 | Bit 0 of write data |
| req_bus | input | 8 | Bus number field |
| req_dev | input | 5 | Device number field |
| req_func | input | 3 | Function number field (carried, not decoded) |
| req_reg | input | 8 | Register byte offset |
| rsp_valid | output | 1 | Response strobe |
| rsp_route | output | 2 | 0 none, 1 internal, 2 type 0, 3 type 1 |
| rsp_retry | output | 1 | Request answered with retry |
| rsp_error | output | 1 | Request flagged, no cycle issued |
| rsp_ones | output | 1 | Read data must be forced to all ones |

## Verification
The only internal state is the enable flag. If it holds the wrong value, the next PCI-side request shows it at the ports at once: a retry appears where an internal route is expected, or an internal route appears where a retry is expected. The bench therefore follows every local write to the option register with a PCI-side probe. A fault in a decode path changes rsp_route or rsp_error in the response cycle itself. A fault in the pipeline stage shows up as a missing or extra rsp_valid one cycle after a request.

// File: rtl/cfg_rg_pkg.sv
// Shared types for the configuration router: route codes, request kinds,
// and the response bundle passed between the decoders and the output stage.
package cfg_rg_pkg;
    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_INT  = 2'd1,
        RT_T0   = 2'd2,
        RT_T1   = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        K_AUTO  = 2'd0,
        K_RSVD  = 2'd1,
        K_T0    = 2'd2,
        K_T1    = 2'd3
    } kind_e;

    typedef struct packed {
        route_e route;
        logic   retry;
        logic   error;
        logic   ones;
    } rsp_t;
endpackage

// File: rtl/cfg_local_decode.sv
// Local-side dispatch. Chooses internal, type 0 or type 1 from the bus and
// device fields, or checks a forced cycle type against the forbidden pairs.
// Assumes: the fields are stable while the request is valid; purely combinational.
module cfg_local_decode
    import cfg_rg_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5
) (
    input  kind_e              kind,
    input  logic               write,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEV_W-1:0]   dev,
    output rsp_t               rsp
);
    logic bus_zero;
    logic dev_zero;
    assign bus_zero = (bus == '0);
    assign dev_zero = (dev == '0);

    // Select a destination, or flag the request if the combination is forbidden.
    always_comb begin
        rsp = '{route: RT_NONE, retry: 1'b0, error: 1'b0, ones: 1'b0};
        unique case (kind)
            K_AUTO: begin
                if (!bus_zero)     rsp.route = RT_T1;
                else if (dev_zero) rsp.route = RT_INT;
                else               rsp.route = RT_T0;
            end
            K_T0: begin
                if (dev_zero) rsp.error = 1'b1;
                else          rsp.route = RT_T0;
            end
            K_T1: begin
                if (bus_zero) rsp.error = 1'b1;
                else          rsp.route = RT_T1;
            end
            default: rsp.error = 1'b1;
        endcase
        rsp.ones = rsp.error & ~write;
    end
endmodule

// File: rtl/cfg_pci_screen.sv
// PCI-side gate. Retries everything while the host enable is clear. Rejects the
// protected offset window, and rejects writes to registers that are read-only
// from PCI. Assumes: a PCI-side request always targets the bridge; combinational.
module cfg_pci_screen
    import cfg_rg_pkg::*;
#(
    parameter int                     REG_W   = 8,
    parameter logic [REG_W-1:0]       PROT_LO = 8'hF0,
    parameter logic [REG_W-1:0]       PROT_HI = 8'hFF,
    parameter int                     RO_N    = 4,
    parameter logic [RO_N*REG_W-1:0]  RO_LO   = {8'h60, 8'h2C, 8'h08, 8'h00},
    parameter logic [RO_N*REG_W-1:0]  RO_HI   = {8'h63, 8'h2F, 8'h0B, 8'h03}
) (
    input  logic               hce,
    input  logic               write,
    input  logic [REG_W-1:0]   regoff,
    output rsp_t               rsp
);
    logic [RO_N-1:0] ro_hit;

    // One range comparator per read-only span.
    for (genvar g = 0; g < RO_N; g++) begin : g_ro
        assign ro_hit[g] = (regoff >= RO_LO[g*REG_W +: REG_W]) &&
                           (regoff <= RO_HI[g*REG_W +: REG_W]);
    end

    logic in_prot;
    assign in_prot = (regoff >= PROT_LO) && (regoff <= PROT_HI);

    // Apply the gate in priority order: retry, protected window, write permission.
    always_comb begin
        rsp = '{route: RT_NONE, retry: 1'b0, error: 1'b0, ones: 1'b0};
        if (!hce)                     rsp.retry = 1'b1;
        else if (in_prot)             rsp.error = 1'b1;
        else if (write && |ro_hit)    rsp.error = 1'b1;
        else                          rsp.route = RT_INT;
        rsp.ones = rsp.error & ~write;
    end
endmodule

// File: rtl/cfg_hce_flag.sv
// Host-configuration enable flag. Loads a new value when the update strobe is set.
// Assumes: synchronous active-low reset; the flag resets to 0.
module cfg_hce_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic val,
    output logic hce
);
    // Hold the enable bit and reload it on a qualified local write.
    always_ff @(posedge clk) begin
        if (!rst_n)   hce <= 1'b0;
        else if (upd) hce <= val;
    end
endmodule

// File: rtl/cfg_route_gate.sv
// Configuration request router and PCI-side gate (top). Selects the local
// decode or the PCI screen by side, and registers a one-cycle response.
// Assumes: at most one request per cycle; req_func is passed through, not decoded.
module cfg_route_gate
    import cfg_rg_pkg::*;
#(
    parameter int               BUS_W     = 8,
    parameter int               DEV_W     = 5,
    parameter int               FUNC_W    = 3,
    parameter int               REG_W     = 8,
    parameter logic [REG_W-1:0] BOPT2_OFF = 8'h60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_side,
    input  logic [1:0]         req_kind,
    input  logic               req_write,
    input  logic               req_wbit0,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEV_W-1:0]   req_dev,
    input  logic [FUNC_W-1:0]  req_func,
    input  logic [REG_W-1:0]   req_reg,
    output logic               rsp_valid,
    output logic [1:0]         rsp_route,
    output logic               rsp_retry,
    output logic               rsp_error,
    output logic               rsp_ones
);
    localparam logic SIDE_PCI = 1'b1;

    rsp_t loc_rsp;
    rsp_t pci_rsp;
    rsp_t sel_rsp;
    rsp_t rsp_q;
    logic hce;
    logic hce_upd;
    logic unused_func;

    assign unused_func = ^req_func;

    cfg_local_decode #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_local (
        .kind  (kind_e'(req_kind)),
        .write (req_write),
        .bus   (req_bus),
        .dev   (req_dev),
        .rsp   (loc_rsp)
    );

    cfg_pci_screen #(.REG_W(REG_W)) u_screen (
        .hce    (hce),
        .write  (req_write),
        .regoff (req_reg),
        .rsp    (pci_rsp)
    );

    // The flag is reloaded only by a local write that lands on the option register.
    assign hce_upd = req_valid && (req_side != SIDE_PCI) && req_write &&
                     (loc_rsp.route == RT_INT) && (req_reg == BOPT2_OFF);

    cfg_hce_flag u_hce (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (hce_upd),
        .val   (req_wbit0),
        .hce   (hce)
    );

    // Pick the decision that belongs to the requesting side.
    always_comb begin
        sel_rsp = (req_side == SIDE_PCI) ? pci_rsp : loc_rsp;
    end

    // Register the response; idle cycles clear every flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '{route: RT_NONE, retry: 1'b0, error: 1'b0, ones: 1'b0};
        end else begin
            rsp_valid <= req_valid;
            rsp_q     <= req_valid ? sel_rsp
                         : '{route: RT_NONE, retry: 1'b0, error: 1'b0, ones: 1'b0};
        end
    end

    assign rsp_route = rsp_q.route;
    assign rsp_retry = rsp_q.retry;
    assign rsp_error = rsp_q.error;
    assign rsp_ones  = rsp_q.ones;
endmodule

// File: rtl/cfg_route_gate_chk.sv
// Temporal checks on the router's ports, bound to every cfg_route_gate instance.
// Assumes: same clock and synchronous active-low reset as the design.
module cfg_route_gate_chk #(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_side,
    input logic [1:0]       req_kind,
    input logic [BUS_W-1:0] req_bus,
    input logic [DEV_W-1:0] req_dev,
    input logic             rsp_valid,
    input logic [1:0]       rsp_route,
    input logic             rsp_retry,
    input logic             rsp_error,
    input logic             rsp_ones
);
    p_resp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_resp_without_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_local_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_side && req_kind == 2'd0 && req_bus == '0 && req_dev == '0)
        |=> (rsp_route == 2'd1 && !rsp_error));

    p_local_type1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_side && req_kind == 2'd0 && req_bus != '0)
        |=> (rsp_route == 2'd3));

    p_error_no_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_route == 2'd0 && !rsp_retry && rsp_valid));

    p_retry_pci_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> ($past(req_side) && rsp_route == 2'd0));

    p_ones_needs_error_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ones |-> rsp_error);
endmodule

bind cfg_route_gate cfg_route_gate_chk #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_side  (req_side),
    .req_kind  (req_kind),
    .req_bus   (req_bus),
    .req_dev   (req_dev),
    .rsp_valid (rsp_valid),
    .rsp_route (rsp_route),
    .rsp_retry (rsp_retry),
    .rsp_error (rsp_error),
    .rsp_ones  (rsp_ones)
);

// File: tb/tb_cfg_route_gate.sv
// Scoreboard bench: the driver computes the expected response from the
// requirements and queues it; the monitor compares each response as it appears.
module tb_cfg_route_gate;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_side = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic       req_write = 1'b0;
    logic       req_wbit0 = 1'b0;
    logic [7:0] req_bus = '0;
    logic [4:0] req_dev = '0;
    logic [2:0] req_func = '0;
    logic [7:0] req_reg = '0;
    logic       rsp_valid;
    logic [1:0] rsp_route;
    logic       rsp_retry;
    logic       rsp_error;
    logic       rsp_ones;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_on = 1'b0;
    bit m_hce  = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    cfg_route_gate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_side(req_side),
        .req_kind(req_kind), .req_write(req_write), .req_wbit0(req_wbit0),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
        .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_retry(rsp_retry),
        .rsp_error(rsp_error), .rsp_ones(rsp_ones)
    );

    function automatic bit ro_pci(input logic [7:0] r);
        return (r <= 8'h03) || (r >= 8'h08 && r <= 8'h0B) ||
               (r >= 8'h2C && r <= 8'h2F) || (r >= 8'h60 && r <= 8'h63);
    endfunction

    // Expected {route, retry, error, ones} from the requirement text.
    function automatic logic [4:0] model(input bit side, input logic [1:0] kind,
                                         input bit wr, input logic [7:0] bus,
                                         input logic [4:0] dev, input logic [7:0] r);
        logic [1:0] rt = 2'd0;
        bit rty = 0, err = 0;
        if (side) begin
            if (!m_hce)                 rty = 1;
            else if (r >= 8'hF0)        err = 1;
            else if (wr && ro_pci(r))   err = 1;
            else                        rt = 2'd1;
        end else begin
            case (kind)
                2'd0: rt = (bus != 0) ? 2'd3 : ((dev == 0) ? 2'd1 : 2'd2);
                2'd2: if (dev == 0) err = 1; else rt = 2'd2;
                2'd3: if (bus == 0) err = 1; else rt = 2'd3;
                default: err = 1;
            endcase
        end
        return {rt, rty, err, err & ~wr};
    endfunction

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got route/retry/err/ones=%b expected %b", tag, act, exp);
        end
    endtask

    // Drive one request for a single cycle and queue its expected response.
    task automatic send(input string tag, input bit side, input logic [1:0] kind,
                        input bit wr, input bit wb, input logic [7:0] bus,
                        input logic [4:0] dev, input logic [7:0] r);
        logic [4:0] e;
        @(negedge clk);
        e = model(side, kind, wr, bus, dev, r);
        if (!side && wr && r == 8'h60 && e[4:3] == 2'd1) m_hce = wb;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1; req_side = side; req_kind = kind; req_write = wr;
        req_wbit0 = wb; req_bus = bus; req_dev = dev; req_reg = r;
        req_func = 3'(r);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: just after each edge, compare a response or confirm silence (R10).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (rsp_valid) begin
                    if (exp_q.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R10: unexpected response got valid=1 expected 0");
                    end else begin
                        check(tag_q.pop_front(),
                              {rsp_route, rsp_retry, rsp_error, rsp_ones},
                              exp_q.pop_front());
                    end
                end else if (exp_q.size() != 0) begin
                    checks++; fails++;
                    void'(tag_q.pop_front());
                    void'(exp_q.pop_front());
                    $display("FAIL R10: missing response got valid=0 expected 1");
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rsp_route, rsp_retry, rsp_error, rsp_ones}, 5'b0);
        check("R1 reset valid", {4'b0, rsp_valid}, 5'b0);
        rst_n = 1;
        mon_on = 1;
        send("R1 R6 retry after reset", 1, 0, 0, 0, 0, 0, 8'h10);
        send("R2 local internal",       0, 0, 0, 0, 0, 0, 8'h04);
        send("R3 local type0",          0, 0, 0, 0, 0, 5, 8'h00);
        send("R4 local type1 dev0",     0, 0, 1, 0, 3, 0, 8'h08);
        send("R4 local type1 max",      0, 0, 0, 0, 8'hFF, 31, 8'h10);
        send("R5 R11 forced t0 dev0",   0, 2, 0, 0, 0, 0, 8'h00);
        send("R5 forced t0 ok",         0, 2, 1, 0, 0, 7, 8'h00);
        send("R5 R11 forced t1 bus0 wr",0, 3, 1, 0, 0, 4, 8'h00);
        send("R5 forced t1 ok",         0, 3, 0, 0, 2, 0, 8'h00);
        send("R5 reserved kind",        0, 1, 0, 0, 0, 0, 8'h00);
        idle(3);
        send("R9 write bopt2 zero",     0, 0, 1, 0, 0, 0, 8'h60);
        send("R9 still retried",        1, 0, 0, 0, 0, 0, 8'h10);
        send("R9 read bopt2",           0, 0, 0, 1, 0, 0, 8'h60);
        send("R9 read leaves flag",     1, 0, 0, 0, 0, 0, 8'h10);
        send("R9 write bopt2 wrong off",0, 0, 1, 1, 0, 0, 8'h61);
        send("R9 offset 61 no effect",  1, 0, 0, 0, 0, 0, 8'h10);
        send("R9 type0 to 60 no effect",0, 0, 1, 1, 0, 3, 8'h60);
        send("R9 t0 write no effect",   1, 0, 0, 0, 0, 0, 8'h10);
        send("R9 enable host cfg",      0, 0, 1, 1, 0, 0, 8'h60);
        send("R9 pci now internal",     1, 0, 0, 0, 0, 0, 8'h10);
        send("R7 R11 prot read",        1, 0, 0, 0, 0, 0, 8'hF4);
        send("R7 prot write top",       1, 0, 1, 0, 0, 0, 8'hFF);
        send("R7 prot edge low",        1, 0, 0, 0, 0, 0, 8'hF0);
        send("R7 below window",         1, 0, 0, 0, 0, 0, 8'hEF);
        send("R8 pci write vendor",     1, 0, 1, 0, 0, 0, 8'h00);
        send("R8 pci read vendor",      1, 0, 0, 0, 0, 0, 8'h00);
        send("R8 pci write subsys",     1, 0, 1, 0, 0, 0, 8'h2F);
        send("R8 pci write class",      1, 0, 1, 0, 0, 0, 8'h0B);
        send("R8 pci write rw reg",     1, 0, 1, 0, 0, 0, 8'h10);
        send("R8 pci write edge 04",    1, 0, 1, 0, 0, 0, 8'h04);
        send("R8 local write vendor",   0, 0, 1, 0, 0, 0, 8'h02);
        send("R8 R9 pci write bopt2",   1, 0, 1, 0, 0, 0, 8'h60);
        send("R9 flag kept after pci",  1, 0, 0, 0, 0, 0, 8'h14);
        send("R12 pci ignores fields",  1, 3, 0, 0, 5, 3, 8'h14);
        send("R12 pci ignores kind",    1, 1, 0, 0, 0, 0, 8'h18);
        idle(4);
        send("R9 disable host cfg",     0, 0, 1, 0, 0, 0, 8'h60);
        send("R6 retry again",          1, 0, 1, 0, 0, 0, 8'h00);
        send("R6 retry prot",           1, 0, 0, 0, 0, 0, 8'hF8);
        idle(3);
        mon_on = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule